// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display. It runs on the pixel clock and keeps a pixel counter and a line counter. From these it derives a blanking flag, CRT horizontal and vertical sync, an active-video flag, and a second sync pair for a flat panel. The panel sync pair has its own registers, so the panel vertical pulse can be placed a line ahead of the CRT pulse.

All geometry sits in 32-bit registers on a simple word-addressed write/read port. Each geometry register holds two counts: a first count in bits [15:0] and a second count in bits [31:16]. Both are stored as the real value minus one. A key register guards every other register. Writes to the other registers are dropped unless the key register holds the unlock key. Software stops the raster by clearing the run and blank-enable bits, and that also forces blanking.

Top module: `raster_timing_gen`

## Requirements
- R1: Word address 0 is the key register. Writing UNLOCK_KEY there unlocks the block, and writing any other value locks it. Reset leaves the block locked, and address 0 reads back 1 when unlocked and 0 when locked. While locked, writes to addresses 1 to 9 leave the stored value unchanged.
- R2: Addresses 1 to 9 read back the last value stored, whatever the lock state. Address 1 is the config register. The pixel-side registers are 2 (active/total), 3 (blank), 4 (sync) and 8 (panel sync). The line-side registers are 5 (active/total), 6 (blank), 7 (sync) and 9 (panel sync). All registers reset to 0, and addresses 10 to 15 read 0.
- R3: While run is set, the pixel counter counts 0, 1, ... up to the total field of register 2 (bits [31:16]), then returns to 0 on the next clock.
- R4: The line counter steps once each time the pixel counter wraps. After the total field of register 5, it returns to 0.
- R5: Config bits are: [0] run, [1] blank enable, [2] hsync enable, [3] vsync enable, [4] panel enable. While run is clear, both counters are 0 on the clock after, and every sync output and active_o are low.
- R6: hsync_o is high when run and hsync enable are set and start+1 <= pixel count < end+1. Here start is bits [15:0] and end is bits [31:16] of register 4.
- R7: vsync_o is high when run and vsync enable are set and the line count lies in the same kind of window taken from register 7.
- R8: blank_o is high when run is clear, or blank enable is clear, or the pixel count is in the register 3 window, or the line count is in the register 6 window.
- R9: active_o is high when run is set, the pixel count is at most bits [15:0] of register 2, and the line count is at most bits [15:0] of register 5.
- R10: With run and panel enable set, panel_en_o is high. In that case pnl_hsync_o follows the register 8 window on the pixel count and pnl_vsync_o follows the register 9 window on the line count. Otherwise all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| hcnt_o | output | 16 | Pixel counter |
| vcnt_o | output | 16 | Line counter |
| blank_o | output | 1 | Blanking flag |
| hsync_o | output | 1 | CRT horizontal sync |
| vsync_o | output | 1 | CRT vertical sync |
| active_o | output | 1 | Active video flag |
| panel_en_o | output | 1 | Panel data/power enable |
| pnl_hsync_o | output | 1 | Panel horizontal sync |
| pnl_vsync_o | output | 1 | Panel vertical sync |

## Verification
The raster runs with two geometries: a small frame with narrow sync pulses and a frame whose widths differ on every axis. Comparing the two separates the use of the start field from the end field, and the pixel registers from the line registers. The panel vertical window is set a line ahead of the CRT window, which shows whether each output reads its own register. Each enable bit is cleared on its own to show which output it gates. Writes made while locked, after a zero key and after a wrong key check the guard, and the stored values are read back through the port after each of them.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NREG    = 10;

  localparam logic [ADDR_W-1:0] A_KEY  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 4'd1;
  localparam logic [ADDR_W-1:0] A_HTOT = 4'd2;
  localparam logic [ADDR_W-1:0] A_HBLK = 4'd3;
  localparam logic [ADDR_W-1:0] A_HSYN = 4'd4;
  localparam logic [ADDR_W-1:0] A_VTOT = 4'd5;
  localparam logic [ADDR_W-1:0] A_VBLK = 4'd6;
  localparam logic [ADDR_W-1:0] A_VSYN = 4'd7;
  localparam logic [ADDR_W-1:0] A_PHSY = 4'd8;
  localparam logic [ADDR_W-1:0] A_PVSY = 4'd9;

  localparam int unsigned CFG_RUN  = 0;
  localparam int unsigned CFG_BLK  = 1;
  localparam int unsigned CFG_HSY  = 2;
  localparam int unsigned CFG_VSY  = 3;
  localparam int unsigned CFG_PNL  = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] stop;
    logic [FIELD_W-1:0] start;
  } span_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h5EC7_1A9B
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NREG-1:1][DATA_W-1:0] regs_o
);
  logic                        open_q;
  logic [NREG-1:1][DATA_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else if (we_i && addr_i == A_KEY) open_q <= (wdata_i == UNLOCK_KEY);
  end

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && open_q && addr_i == MY_ADDR) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_KEY) rdata_o = {{(DATA_W-1){1'b0}}, open_q};
    for (int i = 1; i < NREG; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  assign regs_o = regs_q;

  assert_locked_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && we_i && addr_i != A_KEY) |=> $stable(regs_q));
  assert_key_opens_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_KEY && wdata_i == UNLOCK_KEY) |=> open_q);
  assert_bad_key_closes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_KEY && wdata_i != UNLOCK_KEY) |=> !open_q);
endmodule

// File: rtl/rtg_axis_cnt.sv
module rtg_axis_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // >= so a total shrunk below the live count still wraps at once
  assign wrap_o = en_i && step_i && (cnt_q >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && cnt_q < last_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && cnt_q >= last_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rtg_window.sv
module rtg_window
  import rtg_pkg::*;
(
  input  logic [FIELD_W-1:0] cnt_i,
  input  span_t              span_i,
  output logic               in_o
);
  logic [FIELD_W:0] lo, hi, c;
  assign c    = {1'b0, cnt_i};
  assign lo   = {1'b0, span_i.start} + 1'b1;
  assign hi   = {1'b0, span_i.stop} + 1'b1;
  assign in_o = (c >= lo) && (c < hi);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h5EC7_1A9B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [FIELD_W-1:0] hcnt_o,
  output logic [FIELD_W-1:0] vcnt_o,
  output logic               blank_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               active_o,
  output logic               panel_en_o,
  output logic               pnl_hsync_o,
  output logic               pnl_vsync_o
);
  localparam int unsigned NWIN = 6;
  // window slots: 0 hblank, 1 hsync, 2 panel hsync, 3 vblank, 4 vsync, 5 panel vsync
  localparam logic [ADDR_W-1:0] WIN_ADDR [NWIN] = '{A_HBLK, A_HSYN, A_PHSY, A_VBLK, A_VSYN, A_PVSY};

  logic [NREG-1:1][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           cfg;
  span_t                       htot, vtot;
  logic                        run, h_wrap, v_wrap;
  logic [FIELD_W-1:0]          hcnt, vcnt;
  logic [NWIN-1:0]             win;
  logic                        unused_sig;

  rtg_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .regs_o(regs)
  );

  assign cfg  = regs[A_CFG];
  assign htot = span_t'(regs[A_HTOT]);
  assign vtot = span_t'(regs[A_VTOT]);
  assign run  = cfg[CFG_RUN];
  assign unused_sig = ^{cfg[DATA_W-1:CFG_PNL+1], v_wrap};

  rtg_axis_cnt #(.W(FIELD_W)) u_hcnt (
    .clk_i, .rst_ni, .en_i(run), .step_i(1'b1),
    .last_i(htot.stop), .cnt_o(hcnt), .wrap_o(h_wrap)
  );

  rtg_axis_cnt #(.W(FIELD_W)) u_vcnt (
    .clk_i, .rst_ni, .en_i(run), .step_i(h_wrap),
    .last_i(vtot.stop), .cnt_o(vcnt), .wrap_o(v_wrap)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    rtg_window u_win (
      .cnt_i (g < 3 ? hcnt : vcnt),
      .span_i(span_t'(regs[WIN_ADDR[g]])),
      .in_o  (win[g])
    );
  end

  assign hcnt_o      = hcnt;
  assign vcnt_o      = vcnt;
  assign blank_o     = !run || !cfg[CFG_BLK] || win[0] || win[3];
  assign hsync_o     = run && cfg[CFG_HSY] && win[1];
  assign vsync_o     = run && cfg[CFG_VSY] && win[4];
  assign panel_en_o  = run && cfg[CFG_PNL];
  assign pnl_hsync_o = panel_en_o && win[2];
  assign pnl_vsync_o = panel_en_o && win[5];
  assign active_o    = run && (hcnt <= htot.start) && (vcnt <= vtot.start);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!hsync_o && !vsync_o && !pnl_hsync_o && !pnl_vsync_o && !active_o));
  assert_idle_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> blank_o);
  assert_line_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !h_wrap) |=> $stable(vcnt));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam logic [31:0] KEY = 32'h3C96_0F5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] hcnt, vcnt;
  logic        blank, hsync, vsync, active, pen, phs, pvs;

  int checks = 0;
  int fails  = 0;

  raster_timing_gen #(.UNLOCK_KEY(KEY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hcnt_o(hcnt), .vcnt_o(vcnt), .blank_o(blank),
    .hsync_o(hsync), .vsync_o(vsync), .active_o(active), .panel_en_o(pen),
    .pnl_hsync_o(phs), .pnl_vsync_o(pvs)
  );

  always #2 clk = ~clk;

  // reference model
  int unsigned rg[10];
  bit          opened;
  int unsigned mh, mv;

  function automatic int unsigned lo(int unsigned x); return x & 32'hFFFF; endfunction
  function automatic int unsigned hi(int unsigned x); return x >> 16; endfunction
  function automatic bit inwin(int unsigned c, int unsigned r);
    return (c >= lo(r) + 1) && (c < hi(r) + 1);
  endfunction

  task automatic model_reset();
    foreach (rg[i]) rg[i] = 0;
    opened = 0; mh = 0; mv = 0;
  endtask

  task automatic model_step();
    bit run;
    run = rg[1][0];
    if (!run) begin mh = 0; mv = 0; end
    else if (mh >= hi(rg[2])) begin
      mh = 0;
      if (mv >= hi(rg[5])) mv = 0; else mv++;
    end else mh++;
    if (we) begin
      if (addr == 4'd0) opened = (wdata == KEY);
      else if (opened && addr <= 4'd9) rg[addr] = wdata;
    end
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit run, e_blank, e_hs, e_vs, e_act, e_pen, e_phs, e_pvs;
    int unsigned e_rd;
    run     = rg[1][0];
    e_blank = !run || !rg[1][1] || inwin(mh, rg[3]) || inwin(mv, rg[6]);
    e_hs    = run && rg[1][2] && inwin(mh, rg[4]);
    e_vs    = run && rg[1][3] && inwin(mv, rg[7]);
    e_act   = run && mh <= lo(rg[2]) && mv <= lo(rg[5]);
    e_pen   = run && rg[1][4];
    e_phs   = e_pen && inwin(mh, rg[8]);
    e_pvs   = e_pen && inwin(mv, rg[9]);
    e_rd    = (addr == 0) ? int'(opened) : (addr <= 9 ? rg[addr] : 0);
    chk(hcnt == mh,  "R3 hcnt", hcnt, mh);
    chk(vcnt == mv,  "R4 vcnt", vcnt, mv);
    chk(hsync == e_hs, "R6 hsync", hsync, e_hs);
    chk(vsync == e_vs, "R7 vsync", vsync, e_vs);
    chk(blank == e_blank, "R8 blank", blank, e_blank);
    chk(active == e_act, "R9 active", active, e_act);
    chk(pen == e_pen && phs == e_phs && pvs == e_pvs, "R10 panel",
        {pen, phs, pvs}, {e_pen, e_phs, e_pvs});
    if (addr == 0) chk(rdata == e_rd, "R1 key readback", rdata, e_rd);
    else           chk(rdata == e_rd, "R2 readback", rdata, e_rd);
  endtask

  task automatic cyc(bit w, logic [3:0] a, logic [31:0] d);
    we = w; addr = a; wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    we = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d); cyc(1'b1, a, d); endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'(i % 16), 32'h0);
  endtask

  function automatic logic [31:0] pair(int s, int e);
    return {16'(e - 1), 16'(s - 1)};
  endfunction

  bit done = 0;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare(); // reset state R1 R2 R5
    rst_n = 1'b1;
    // R1: locked writes dropped
    wr(4'd1, 32'h1F);
    wr(4'd2, 32'hFFFF_FFFF);
    idle(4);
    // unlock and program geometry A: 8 active of 14, 4 active lines of 7
    wr(4'd0, KEY);
    idle(2);
    wr(4'd2, pair(8, 14));
    wr(4'd3, pair(8, 14));
    wr(4'd4, pair(10, 12));
    wr(4'd8, pair(10, 12));
    wr(4'd5, pair(4, 7));
    wr(4'd6, pair(4, 7));
    wr(4'd7, pair(5, 6));
    wr(4'd9, pair(4, 5));   // panel vsync a line ahead
    wr(4'd1, 32'h1F);
    idle(300);
    // R6 R10: drop hsync enable, then panel enable
    wr(4'd1, 32'h1B);
    idle(120);
    wr(4'd1, 32'h0F);
    idle(120);
    // R8: blank enable cleared while running
    wr(4'd1, 32'h1D);
    idle(120);
    // R1: zero key relocks; writes ignored
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h0);
    wr(4'd4, 32'h0);
    idle(60);
    // geometry B, different on every axis
    wr(4'd0, KEY);
    wr(4'd2, pair(11, 19));
    wr(4'd3, pair(12, 19));
    wr(4'd4, pair(13, 16));
    wr(4'd8, pair(14, 17));
    wr(4'd5, pair(3, 9));
    wr(4'd6, pair(4, 9));
    wr(4'd7, pair(5, 7));
    wr(4'd9, pair(4, 6));
    wr(4'd1, 32'h1F);
    idle(500);
    // shrink total below live count
    wr(4'd2, pair(3, 5));
    idle(80);
    // R1: wrong key locks
    wr(4'd0, KEY ^ 32'h1);
    wr(4'd1, 32'h0);
    idle(40);
    // R5: stop generator and blanking
    wr(4'd0, KEY);
    wr(4'd1, 32'h1C);
    idle(40);
    wr(4'd1, 32'h0);
    idle(20);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule